// File: doc/BRIEF.md
# Prioritized Memory Protection Region Checker

This block sits beside a processor's data path and judges every access against a bank of programmable protection regions. Each region is placed by a base address and a power-of-two size, can be switched on or off as a whole, and is cut into eight equal slices that can each be switched off on their own. Each region also carries a three-bit permission code and a no-execute flag. When regions overlap, the higher-numbered one decides. An address that lands in a switched-off slice is not claimed by that region, so the next lower region that covers the address decides instead.

The access side takes an address, a byte count given as a power of two, a write flag, an instruction-fetch flag and a privilege flag. Both the first and the last byte of the access are looked up, so an access that straddles a slice border is refused if either end is refused. One clock after the request the block returns a fault flag, a cause code, the deciding region, and the address of the byte that faulted. An optional catch-all region covers the whole 4 GB space for privileged code only. A global enable input turns all checking off.

Region settings are written one word at a time through a simple write port: a base word, a size word and an access-control word per region.

Top module: `mpu_region_guard`

## Requirements
- R1: A request presented with `acc_valid` high is answered with `rsp_valid` high exactly one clock later; without a request `rsp_valid` and `rsp_fault` stay low.
- R2: In the size word, bit 0 enables the region, bits [5:1] hold size code N giving a span of 2^(N+1) bytes (code 4 = 32 bytes, code 31 = 4 GB); codes 0 to 3 never match, and a disabled region never matches.
- R3: Base address bits below the region span are ignored in the compare, so a base written with stray low bits behaves as the aligned base.
- R4: Among regions that match an address, the highest-numbered one decides, and its number is reported on `rsp_region` with `rsp_hit` high.
- R5: Size-word bits [15:8] switch off slices: bit 8+k switches off slice k, where k is address bits [N:N-2]; an address in a switched-off slice falls through to the next lower matching region.
- R6: Access-control bits [10:8] hold the permission code: 000 none, 001 privileged read/write only, 010 privileged read/write and user read, 011 read/write for all, 101 privileged read only, 110 read only for all, 100 and 111 none; a refused access faults with cause 1.
- R7: Access-control bit 12 is the no-execute flag; an instruction fetch from such a region faults with cause 2, and a fetch otherwise needs read permission.
- R8: An address no region claims is allowed for a privileged access when `bg_en` is high (with `rsp_hit` low); otherwise it faults with cause 3 and `rsp_hit` low.
- R9: The last byte address is the start plus 2^`acc_size` minus 1; the access faults if either end faults, the start end is reported first, and `rsp_fault_addr` gives the faulting byte's address (0 when no fault).
- R10: With `guard_en` low every access is answered without fault, with `rsp_hit` low and cause 0.
- R11: After reset every region is disabled with all slices on, the permission code is 000 and no response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| guard_en | input | 1 | Global checking enable; low lets every access through |
| bg_en | input | 1 | Enables the privileged catch-all region |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_region | input | IDX_W | Region number being written |
| cfg_sel | input | 2 | Word select: 0 base, 1 size word, 2 access-control word, 3 ignored |
| cfg_wdata | input | 32 | Configuration write data |
| acc_valid | input | 1 | Access request strobe |
| acc_addr | input | 32 | Start byte address of the access |
| acc_size | input | 2 | Access byte count as log2 (0 = 1 byte .. 3 = 8 bytes) |
| acc_write | input | 1 | Write access when high, read when low |
| acc_fetch | input | 1 | Instruction fetch (treated as a read) |
| acc_priv | input | 1 | Privileged access when high |
| rsp_valid | output | 1 | Response strobe, one clock after the request |
| rsp_fault | output | 1 | Access refused |
| rsp_cause | output | 2 | 0 none, 1 permission, 2 no-execute, 3 no region |
| rsp_hit | output | 1 | A region decided the reported end |
| rsp_region | output | IDX_W | Number of the deciding region |
| rsp_fault_addr | output | 32 | Address of the faulting byte, 0 without fault |

## Verification
On every cycle the assertions tie the response timing to the request, keep the bypass path free of faults, tie each cause code to the fault flag, forbid a user access from passing with no region, allow the no-execute cause only for fetches, and require the reported fault address to be one of the two access ends. Which region wins an overlap, how a switched-off slice hands the address to a lower region, the full permission table, invalid size codes, the 4 GB size and border-straddling accesses depend on programmed contents and are shown only by the directed scenarios of the bench.

// File: rtl/mpu_guard_pkg.sv
// Shared types and constants of the protection region checker.
// Assumes a 32-bit byte address space.
package mpu_guard_pkg;

    localparam int ADDR_W = 32;

    // Word selects of the configuration write port
    localparam logic [1:0] SEL_BASE = 2'd0;
    localparam logic [1:0] SEL_SIZE = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;

    // Smallest legal size code (32-byte span)
    localparam logic [4:0] MIN_SIZE_CODE = 5'd4;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'd0,
        CAUSE_PERM    = 2'd1,
        CAUSE_XN      = 2'd2,
        CAUSE_NOMATCH = 2'd3
    } fault_cause_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [4:0]        size_code;
        logic              enable;
        logic [7:0]        slice_off;
        logic [2:0]        perm;
        logic              no_exec;
    } region_cfg_t;

endpackage

// File: rtl/mpu_region_cfg.sv
// Configuration storage for all protection regions.
// One register set per region, written one word at a time. Writes whose
// region number has no register set are dropped. Reset disables everything.
module mpu_region_cfg
    import mpu_guard_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int IDX_W       = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [1:0]        sel,
    input  logic [ADDR_W-1:0] wdata,
    output region_cfg_t       cfg [NUM_REGIONS]
);

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
        region_cfg_t r_q;

        // Capture the selected word for this region
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                r_q <= '0;
            end else if (we && idx == IDX_W'(g)) begin
                case (sel)
                    SEL_BASE: r_q.base <= wdata;
                    SEL_SIZE: begin
                        r_q.enable    <= wdata[0];
                        r_q.size_code <= wdata[5:1];
                        r_q.slice_off <= wdata[15:8];
                    end
                    SEL_CTRL: begin
                        r_q.perm    <= wdata[10:8];
                        r_q.no_exec <= wdata[12];
                    end
                    default: ;
                endcase
            end
        end

        assign cfg[g] = r_q;
    end

endmodule

// File: rtl/mpu_region_match.sv
// Address match of one region against one byte address.
// Matches when the region is enabled, its size code is legal, the address
// bits above the span equal the base, and the slice holding the address is on.
module mpu_region_match
    import mpu_guard_pkg::*;
(
    input  region_cfg_t       cfg,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);

    logic [5:0]        span_log2;
    logic [4:0]        slice_shift;
    logic [ADDR_W-1:0] keep_mask;
    logic [2:0]        slice_idx;
    logic              size_ok;
    logic              base_eq;

    // Derive compare mask and slice index from the size code
    always_comb begin
        size_ok     = cfg.size_code >= MIN_SIZE_CODE;
        span_log2   = {1'b0, cfg.size_code} + 6'd1;
        keep_mask   = {ADDR_W{1'b1}} << span_log2;
        slice_shift = cfg.size_code - 5'd2;
        slice_idx   = 3'(addr >> slice_shift);
        base_eq     = (addr & keep_mask) == (cfg.base & keep_mask);
        hit         = cfg.enable && size_ok && base_eq && !cfg.slice_off[slice_idx];
    end

endmodule

// File: rtl/mpu_priority_pick.sv
// Picks the highest-numbered region from a vector of match flags.
module mpu_priority_pick #(
    parameter int NUM_REGIONS = 8,
    parameter int IDX_W       = 3
) (
    input  logic [NUM_REGIONS-1:0] hits,
    output logic                   any,
    output logic [IDX_W-1:0]       idx
);

    // Ascending scan: the last match seen is the highest priority
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (hits[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/mpu_perm_eval.sv
// Permission decision for one access end.
// Assumes the permission code and no-execute flag belong to the winning
// region when hit is high; fetches are judged as reads.
module mpu_perm_eval
    import mpu_guard_pkg::*;
(
    input  logic         hit,
    input  logic [2:0]   perm,
    input  logic         no_exec,
    input  logic         bg_en,
    input  logic         priv,
    input  logic         write,
    input  logic         fetch,
    output logic         fault,
    output fault_cause_e cause
);

    logic rd_ok;
    logic wr_ok;
    logic is_write;

    // Decode the permission code for the current privilege
    always_comb begin
        rd_ok = 1'b0;
        wr_ok = 1'b0;
        case (perm)
            3'b001: begin rd_ok = priv; wr_ok = priv; end
            3'b010: begin rd_ok = 1'b1; wr_ok = priv; end
            3'b011: begin rd_ok = 1'b1; wr_ok = 1'b1; end
            3'b101: begin rd_ok = priv; end
            3'b110: begin rd_ok = 1'b1; end
            default: ;
        endcase
    end

    // Combine match, no-execute and permission into a verdict
    always_comb begin
        is_write = write && !fetch;
        fault    = 1'b0;
        cause    = CAUSE_NONE;
        if (!hit) begin
            if (!(bg_en && priv)) begin
                fault = 1'b1;
                cause = CAUSE_NOMATCH;
            end
        end else if (fetch && no_exec) begin
            fault = 1'b1;
            cause = CAUSE_XN;
        end else if (is_write ? !wr_ok : !rd_ok) begin
            fault = 1'b1;
            cause = CAUSE_PERM;
        end
    end

endmodule

// File: rtl/mpu_region_guard.sv
// Top of the protection region checker.
// Looks up the first and last byte of each access in all regions in
// parallel, picks the highest-numbered match per end, judges permissions
// and registers a single response one clock after the request.
// Assumes NUM_REGIONS is 8 or 12 and accesses of at most 8 bytes.
module mpu_region_guard
    import mpu_guard_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    localparam int IDX_W      = $clog2(NUM_REGIONS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              guard_en,
    input  logic              bg_en,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_region,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    input  logic              acc_write,
    input  logic              acc_fetch,
    input  logic              acc_priv,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [1:0]        rsp_cause,
    output logic              rsp_hit,
    output logic [IDX_W-1:0]  rsp_region,
    output logic [ADDR_W-1:0] rsp_fault_addr
);

    localparam int ENDS = 2;

    region_cfg_t       cfg [NUM_REGIONS];
    logic [ADDR_W-1:0] end_addr [ENDS];
    logic              end_any  [ENDS];
    logic [IDX_W-1:0]  end_idx  [ENDS];
    logic              end_flt  [ENDS];
    fault_cause_e      end_cause[ENDS];

    mpu_region_cfg #(
        .NUM_REGIONS(NUM_REGIONS),
        .IDX_W      (IDX_W)
    ) cfg_i (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (cfg_we),
        .idx  (cfg_region),
        .sel  (cfg_sel),
        .wdata(cfg_wdata),
        .cfg  (cfg)
    );

    // Start byte and last byte of the access
    assign end_addr[0] = acc_addr;
    assign end_addr[1] = acc_addr + ((ADDR_W'(1) << acc_size) - ADDR_W'(1));

    for (genvar e = 0; e < ENDS; e++) begin : g_end
        logic [NUM_REGIONS-1:0] hits;
        logic [2:0]             win_perm;
        logic                   win_xn;

        for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_match
            mpu_region_match match_i (
                .cfg (cfg[r]),
                .addr(end_addr[e]),
                .hit (hits[r])
            );
        end

        mpu_priority_pick #(
            .NUM_REGIONS(NUM_REGIONS),
            .IDX_W      (IDX_W)
        ) pick_i (
            .hits(hits),
            .any (end_any[e]),
            .idx (end_idx[e])
        );

        // Fetch the attributes of the winning region
        always_comb begin
            win_perm = 3'b000;
            win_xn   = 1'b0;
            for (int i = 0; i < NUM_REGIONS; i++) begin
                if (end_idx[e] == IDX_W'(i)) begin
                    win_perm = cfg[i].perm;
                    win_xn   = cfg[i].no_exec;
                end
            end
        end

        mpu_perm_eval eval_i (
            .hit    (end_any[e]),
            .perm   (win_perm),
            .no_exec(win_xn),
            .bg_en  (bg_en),
            .priv   (acc_priv),
            .write  (acc_write),
            .fetch  (acc_fetch),
            .fault  (end_flt[e]),
            .cause  (end_cause[e])
        );
    end

    logic              nxt_fault;
    logic [1:0]        nxt_cause;
    logic              nxt_hit;
    logic [IDX_W-1:0]  nxt_region;
    logic [ADDR_W-1:0] nxt_faddr;

    // Merge the two ends: start end reported first, bypass when disabled
    always_comb begin
        nxt_fault  = 1'b0;
        nxt_cause  = CAUSE_NONE;
        nxt_hit    = 1'b0;
        nxt_region = '0;
        nxt_faddr  = '0;
        if (guard_en) begin
            if (end_flt[0]) begin
                nxt_fault  = 1'b1;
                nxt_cause  = end_cause[0];
                nxt_hit    = end_any[0];
                nxt_region = end_any[0] ? end_idx[0] : '0;
                nxt_faddr  = end_addr[0];
            end else if (end_flt[1]) begin
                nxt_fault  = 1'b1;
                nxt_cause  = end_cause[1];
                nxt_hit    = end_any[1];
                nxt_region = end_any[1] ? end_idx[1] : '0;
                nxt_faddr  = end_addr[1];
            end else begin
                nxt_hit    = end_any[0];
                nxt_region = end_any[0] ? end_idx[0] : '0;
            end
        end
    end

    // Register the response one clock after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid      <= 1'b0;
            rsp_fault      <= 1'b0;
            rsp_cause      <= CAUSE_NONE;
            rsp_hit        <= 1'b0;
            rsp_region     <= '0;
            rsp_fault_addr <= '0;
        end else begin
            rsp_valid      <= acc_valid;
            rsp_fault      <= acc_valid && nxt_fault;
            rsp_cause      <= acc_valid ? nxt_cause : CAUSE_NONE;
            rsp_hit        <= acc_valid && nxt_hit;
            rsp_region     <= acc_valid ? nxt_region : '0;
            rsp_fault_addr <= acc_valid ? nxt_faddr : '0;
        end
    end

endmodule

// File: rtl/mpu_region_guard_chk.sv
// Cycle-level properties of the protection region checker, bound to the top.
module mpu_region_guard_chk #(
    parameter int NUM_REGIONS = 8,
    localparam int IDX_W      = $clog2(NUM_REGIONS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             guard_en,
    input logic             acc_valid,
    input logic [31:0]      acc_addr,
    input logic [1:0]       acc_size,
    input logic             acc_fetch,
    input logic             acc_priv,
    input logic             rsp_valid,
    input logic             rsp_fault,
    input logic [1:0]       rsp_cause,
    input logic             rsp_hit,
    input logic [IDX_W-1:0] rsp_region,
    input logic [31:0]      rsp_fault_addr
);

    assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> rsp_valid);

    assert_idle_no_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (!rsp_valid && !rsp_fault));

    assert_bypass_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !guard_en) |=> (!rsp_fault && !rsp_hit && rsp_cause == 2'd0));

    assert_cause_tracks_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_fault == (rsp_cause != 2'd0)));

    assert_user_no_background_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault && !rsp_hit) |-> ($past(acc_priv) || !$past(guard_en)));

    assert_nomatch_no_region_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_fault && rsp_cause == 2'd3) |-> (!rsp_hit && rsp_region == '0));

    assert_xn_needs_fetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_fault && rsp_cause == 2'd2) |-> $past(acc_fetch));

    assert_fault_addr_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> ((rsp_fault_addr == $past(acc_addr)) ||
                       (rsp_fault_addr - $past(acc_addr) == ((32'd1 << $past(acc_size)) - 32'd1))));

endmodule

bind mpu_region_guard mpu_region_guard_chk #(.NUM_REGIONS(NUM_REGIONS)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .guard_en      (guard_en),
    .acc_valid     (acc_valid),
    .acc_addr      (acc_addr),
    .acc_size      (acc_size),
    .acc_fetch     (acc_fetch),
    .acc_priv      (acc_priv),
    .rsp_valid     (rsp_valid),
    .rsp_fault     (rsp_fault),
    .rsp_cause     (rsp_cause),
    .rsp_hit       (rsp_hit),
    .rsp_region    (rsp_region),
    .rsp_fault_addr(rsp_fault_addr)
);

// File: tb/mpu_region_guard_tb_top.sv
// Directed bench for the protection region checker: one task per scenario.
module mpu_region_guard_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        guard_en = 1'b0;
    logic        bg_en = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_region = '0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_size = '0;
    logic        acc_write = 1'b0;
    logic        acc_fetch = 1'b0;
    logic        acc_priv = 1'b0;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [1:0]  rsp_cause;
    logic        rsp_hit;
    logic [2:0]  rsp_region;
    logic [31:0] rsp_fault_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    mpu_region_guard dut_i (
        .clk(clk), .rst_n(rst_n), .guard_en(guard_en), .bg_en(bg_en),
        .cfg_we(cfg_we), .cfg_region(cfg_region), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_size(acc_size),
        .acc_write(acc_write), .acc_fetch(acc_fetch), .acc_priv(acc_priv),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
        .rsp_hit(rsp_hit), .rsp_region(rsp_region), .rsp_fault_addr(rsp_fault_addr)
    );

    task automatic write_word(input int idx, input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_region = 3'(idx); cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_region(input int idx, input logic [31:0] base, input logic [4:0] code,
                              input logic en, input logic [7:0] off, input logic [2:0] ap,
                              input logic xn);
        write_word(idx, 2'd0, base);
        write_word(idx, 2'd1, {16'h0, off, 2'b00, code, en});
        write_word(idx, 2'd2, {19'h0, xn, 1'b0, ap, 8'h00});
    endtask

    // Issue one access and compare the whole response one clock later
    task automatic probe(input string tag, input logic [31:0] addr, input logic [1:0] sz,
                         input logic wr, input logic fe, input logic pv,
                         input logic e_fault, input logic [1:0] e_cause, input logic e_hit,
                         input logic [2:0] e_region, input logic [31:0] e_faddr);
        logic [39:0] act;
        logic [39:0] exp;
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = addr; acc_size = sz;
        acc_write = wr; acc_fetch = fe; acc_priv = pv;
        @(negedge clk);
        acc_valid = 1'b0;
        act = {rsp_valid, rsp_fault, rsp_cause, rsp_hit, rsp_region, rsp_fault_addr};
        exp = {1'b1, e_fault, e_cause, e_hit, e_region, e_faddr};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s addr=%h: actual v/f/c/h/r/fa=%b/%b/%0d/%b/%0d/%h expected %b/%b/%0d/%b/%0d/%h",
                     tag, addr, act[39], act[38], act[37:36], act[35], act[34:32], act[31:0],
                     exp[39], exp[38], exp[37:36], exp[35], exp[34:32], exp[31:0]);
        end
    endtask

    function automatic logic perm_ok(input logic [2:0] ap, input logic pv, input logic wr);
        logic rd, w;
        rd = pv ? (ap inside {3'b001, 3'b010, 3'b011, 3'b101, 3'b110})
                : (ap inside {3'b010, 3'b011, 3'b110});
        w  = pv ? (ap inside {3'b001, 3'b010, 3'b011}) : (ap == 3'b011);
        return wr ? w : rd;
    endfunction

    task automatic t_reset_state();
        checks++;
        if (rsp_valid !== 1'b0 || rsp_fault !== 1'b0) begin
            fails++;
            $display("FAIL R11 reset: actual valid=%b fault=%b expected 0 0", rsp_valid, rsp_fault);
        end
        // R11: all regions disabled, no background -> no match
        probe("R11 empty after reset", 32'h0000_1000, 2'd2, 1'b0, 1'b0, 1'b1,
              1'b1, 2'd3, 1'b0, 3'd0, 32'h0000_1000);
        // R1: idle cycle gives no response
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1 idle: actual valid=%b expected 0", rsp_valid);
        end
    endtask

    task automatic t_bypass();
        guard_en = 1'b0;
        probe("R10 bypass user write", 32'h0000_1000, 2'd2, 1'b1, 1'b0, 1'b0,
              1'b0, 2'd0, 1'b0, 3'd0, 32'h0);
        guard_en = 1'b1;
    endtask

    task automatic t_overlap_slices();
        // Region 2: 2 MB full access; region 5: 4 KB no access, slices 1 and 2 off,
        // base written with stray low bits (R3)
        set_region(2, 32'h0800_0000, 5'd20, 1'b1, 8'h00, 3'b011, 1'b0);
        set_region(5, 32'h0800_40A4, 5'd11, 1'b1, 8'h06, 3'b000, 1'b0);
        probe("R4 R3 higher region wins", 32'h0800_4000, 2'd2, 1'b1, 1'b0, 1'b0,
              1'b1, 2'd1, 1'b1, 3'd5, 32'h0800_4000);
        probe("R5 off slice falls through", 32'h0800_4200, 2'd2, 1'b1, 1'b0, 1'b0,
              1'b0, 2'd0, 1'b1, 3'd2, 32'h0);
        probe("R9 border between two off slices", 32'h0800_43FE, 2'd2, 1'b1, 1'b0, 1'b0,
              1'b0, 2'd0, 1'b1, 3'd2, 32'h0);
        probe("R9 end spills into live slice", 32'h0800_45FE, 2'd2, 1'b1, 1'b0, 1'b0,
              1'b1, 2'd1, 1'b1, 3'd5, 32'h0800_4601);
        probe("R9 start end reported first", 32'h0800_41FE, 2'd2, 1'b1, 1'b0, 1'b0,
              1'b1, 2'd1, 1'b1, 3'd5, 32'h0800_41FE);
        probe("R3 just above region 5", 32'h0800_5000, 2'd2, 1'b1, 1'b0, 1'b0,
              1'b0, 2'd0, 1'b1, 3'd2, 32'h0);
        probe("R9 end leaves region 5 at top", 32'h0800_4FFE, 2'd2, 1'b0, 1'b0, 1'b1,
              1'b1, 2'd1, 1'b1, 3'd5, 32'h0800_4FFE);
    endtask

    task automatic t_perm_table();
        for (int ap = 0; ap < 8; ap++) begin
            set_region(7, 32'h2000_0000, 5'd4, 1'b1, 8'h00, 3'(ap), 1'b0);
            for (int m = 0; m < 4; m++) begin
                logic pv, wr, ok;
                pv = m[0]; wr = m[1];
                ok = perm_ok(3'(ap), pv, wr);
                probe($sformatf("R6 code %0d priv %0d write %0d", ap, pv, wr),
                      32'h2000_0010, 2'd0, wr, 1'b0, pv,
                      !ok, ok ? 2'd0 : 2'd1, 1'b1, 3'd7, ok ? 32'h0 : 32'h2000_0010);
            end
        end
    endtask

    task automatic t_no_exec();
        set_region(7, 32'h2000_0000, 5'd4, 1'b1, 8'h00, 3'b011, 1'b1);
        probe("R7 fetch from no-exec", 32'h2000_0004, 2'd2, 1'b0, 1'b1, 1'b1,
              1'b1, 2'd2, 1'b1, 3'd7, 32'h2000_0004);
        probe("R7 read from no-exec", 32'h2000_0004, 2'd2, 1'b0, 1'b0, 1'b0,
              1'b0, 2'd0, 1'b1, 3'd7, 32'h0);
        set_region(7, 32'h2000_0000, 5'd4, 1'b1, 8'h00, 3'b001, 1'b0);
        probe("R7 user fetch needs read", 32'h2000_0004, 2'd2, 1'b0, 1'b1, 1'b0,
              1'b1, 2'd1, 1'b1, 3'd7, 32'h2000_0004);
        probe("R7 privileged fetch allowed", 32'h2000_0004, 2'd2, 1'b1, 1'b1, 1'b1,
              1'b0, 2'd0, 1'b1, 3'd7, 32'h0);
    endtask

    task automatic t_size_codes();
        set_region(6, 32'h3000_0000, 5'd3, 1'b1, 8'h00, 3'b011, 1'b0);
        probe("R2 size code 3 never matches", 32'h3000_0000, 2'd0, 1'b0, 1'b0, 1'b1,
              1'b1, 2'd3, 1'b0, 3'd0, 32'h3000_0000);
        set_region(6, 32'h3000_0000, 5'd4, 1'b1, 8'h00, 3'b011, 1'b0);
        probe("R2 size code 4 matches", 32'h3000_001F, 2'd0, 1'b0, 1'b0, 1'b1,
              1'b0, 2'd0, 1'b1, 3'd6, 32'h0);
        probe("R2 32-byte span ends", 32'h3000_0020, 2'd0, 1'b0, 1'b0, 1'b1,
              1'b1, 2'd3, 1'b0, 3'd0, 32'h3000_0020);
        set_region(6, 32'h3000_0000, 5'd4, 1'b0, 8'h00, 3'b011, 1'b0);
        probe("R2 disabled region", 32'h3000_0000, 2'd0, 1'b0, 1'b0, 1'b1,
              1'b1, 2'd3, 1'b0, 3'd0, 32'h3000_0000);
    endtask

    task automatic t_background();
        bg_en = 1'b1;
        probe("R8 privileged background", 32'h4000_0000, 2'd3, 1'b1, 1'b0, 1'b1,
              1'b0, 2'd0, 1'b0, 3'd0, 32'h0);
        probe("R8 user gets no background", 32'h4000_0000, 2'd3, 1'b0, 1'b0, 1'b0,
              1'b1, 2'd3, 1'b0, 3'd0, 32'h4000_0000);
        bg_en = 1'b0;
        probe("R8 background off", 32'h4000_0000, 2'd3, 1'b0, 1'b0, 1'b1,
              1'b1, 2'd3, 1'b0, 3'd0, 32'h4000_0000);
    endtask

    task automatic t_full_space();
        // Region 0 spans 4 GB, read-only for all, top slice switched off
        set_region(0, 32'h0000_0000, 5'd31, 1'b1, 8'h80, 3'b110, 1'b0);
        probe("R2 4GB region user read", 32'h1000_0000, 2'd2, 1'b0, 1'b0, 1'b0,
              1'b0, 2'd0, 1'b1, 3'd0, 32'h0);
        probe("R6 4GB region user write refused", 32'h1000_0000, 2'd2, 1'b1, 1'b0, 1'b0,
              1'b1, 2'd1, 1'b1, 3'd0, 32'h1000_0000);
        probe("R5 top slice off no match", 32'hF000_0000, 2'd2, 1'b0, 1'b0, 1'b0,
              1'b1, 2'd3, 1'b0, 3'd0, 32'hF000_0000);
        probe("R4 region 2 over region 0", 32'h0800_4200, 2'd2, 1'b1, 1'b0, 1'b0,
              1'b0, 2'd0, 1'b1, 3'd2, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        guard_en = 1'b1;
        t_reset_state();
        t_bypass();
        t_overlap_slices();
        t_perm_table();
        t_no_exec();
        t_size_codes();
        t_background();
        t_full_space();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung run expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule